// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block is the sending half of a keyboard-like device on a two-wire open-collector clock/data link. The device generates the clock. Bytes arrive on a valid/ready interface and go into a one-byte holding buffer. The block then serialises each byte as an 11-bit frame on the line. Both wires are driven only through output enables: asserting an enable pulls that wire low, and releasing it lets the wire float high. The block also samples both wires, through a synchroniser, so that it can see the host pulling a line low.

A one-microsecond tick from an external prescaler times every phase. The defaults sit inside the allowed windows:

| Interval | Default | Allowed range |
|---|---|---|
| Clock low | 32 µs | 30–35 µs |
| Clock high | 38 µs | 30–45 µs |
| Full cycle | 70 µs | 60–80 µs |
| Data set-up before a falling clock edge | 11 µs | 8–14 µs |
| Data hold after a falling edge | 59 µs | 45–62 µs |

Before starting a frame, the block waits until both wires read high. If the host pulls the clock low during a frame, the block abandons the frame and keeps the byte, provided the parity bit's rising clock edge has not yet happened. Once that edge has passed, the block finishes the frame.

Top module: `ps2_dev_tx`

## Requirements
- R1: Each frame carries 11 bits, in this order: a start bit of 0, the eight data bits least significant first, a parity bit, and a stop bit of 1. A bit's value is the level of the data wire at the falling edge of that bit's clock. For byte 58h, the whole sequence is 0, 0,0,0,1,1,0,1,0, 0, 1.
- R2: Parity is odd: the eight data bits and the parity bit together contain an odd number of ones.
- R3: Every clock low phase lasts between 30 and 35 ticks (32 by default).
- R4: Within a frame, every clock high phase lasts between 30 and 45 ticks (38 by default). Clock enable changes happen only in the cycle after a tick.
- R5: When the data wire changes, it does so at least 8 and at most 14 ticks before the next falling clock edge. The data wire then stays unchanged for 45 to 62 ticks after that falling edge, and never changes while the clock is pulled low.
- R6: While the host holds either wire low, a buffered byte is not sent: both enables stay released. The frame starts after both wires are released.
- R7: A host clock inhibit seen before the parity bit's rising clock edge ends the frame. Both wires are released, the byte is kept, and the whole frame is sent again after the inhibit ends.
- R8: A host clock inhibit that begins after the parity bit's rising clock edge does not stop the frame. The stop bit is sent, and the byte is not sent a second time.
- R9: in_ready is low from the cycle after a byte is accepted until the frame carrying it completes without an abort. An aborted frame leaves in_ready low.
- R10: During and just after reset, both output enables are released and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The holding buffer is free |
| in_byte | input | 8 | Byte to send |
| ps2_clk_in | input | 1 | Sampled level of the clock wire |
| ps2_dat_in | input | 1 | Sampled level of the data wire |
| ps2_clk_oe | output | 1 | 1 pulls the clock wire low |
| ps2_dat_oe | output | 1 | 1 pulls the data wire low |

## Verification
The hardest case to reach is an inhibit that lands close to the parity boundary: on one side it must abort the frame and on the other it must let the frame finish. The stimulus handles this by counting the falling clock edges it has already captured. In one test it pulls the clock wire low in the middle of a frame, after four bits, and expects a full retransmission that the scoreboard matches against the same queued frame. In another it waits for the parity bit's falling edge and then its rising edge, pulls the clock low at once, and expects the frame to complete with no second copy.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    // frame bit positions; the transmit order runs from bit 0 upward
    localparam int FRAME_BITS = 11;
    localparam int PAR_POS    = 9;
    localparam int STOP_POS   = 10;

    // default phase lengths in microsecond ticks
    localparam int DEF_T_LOW   = 32;
    localparam int DEF_T_HIGH  = 38;
    localparam int DEF_T_SETUP = 11;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    typedef struct packed {
        logic       stop;
        logic       parity;
        logic [7:0] payload;
        logic       start;
    } frame_t;

    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic frame_t make_frame(input logic [7:0] b);
        frame_t f;
        f.start   = 1'b0;
        f.payload = b;
        f.parity  = odd_parity(b);
        f.stop    = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '1;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ps2tx_hold.sv
module ps2tx_hold (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic       consume,
    output logic       have_byte,
    output logic [7:0] held_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            have_byte <= 1'b0;
            held_byte <= '0;
        end else if (consume) begin
            have_byte <= 1'b0;
        end else if (in_valid && !have_byte) begin
            have_byte <= 1'b1;
            held_byte <= in_byte;
        end
    end

    assign in_ready = !have_byte;
endmodule

// File: rtl/ps2tx_tick_cnt.sv
module ps2tx_tick_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ps2tx_frame.sv
module ps2tx_frame
    import ps2tx_pkg::*;
#(
    parameter int T_LOW   = DEF_T_LOW,
    parameter int T_HIGH  = DEF_T_HIGH,
    parameter int T_SETUP = DEF_T_SETUP,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             have_byte,
    input  logic [7:0]       held_byte,
    input  logic             clk_hi,
    input  logic             dat_hi,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             consume,
    output logic             clk_low,
    output logic             dat_low
);
    localparam logic [3:0]       STOP_IDX  = 4'(STOP_POS);
    localparam logic [CNT_W-1:0] HIGH_END  = CNT_W'(T_HIGH - 1);
    localparam logic [CNT_W-1:0] LOW_END   = CNT_W'(T_LOW - 1);
    localparam logic [CNT_W-1:0] DATA_AT   = CNT_W'(T_HIGH - T_SETUP - 1);
    // skip the first ticks of a high phase so the synchroniser has caught up
    localparam logic [CNT_W-1:0] WATCH_MIN = CNT_W'(2);

    phase_e     ph;
    logic [3:0] idx;
    frame_t     frm;
    logic       host_hold;
    logic       abort_now;
    logic       phase_end;

    assign host_hold = (cnt >= WATCH_MIN) && !clk_hi;
    assign abort_now = (ph == PH_HIGH) && tick && host_hold && (idx != STOP_IDX);

    always_comb begin
        phase_end = 1'b0;
        case (ph)
            PH_HIGH: phase_end = tick && (cnt == HIGH_END);
            PH_LOW:  phase_end = tick && (cnt == LOW_END);
            PH_TAIL: phase_end = tick && (cnt == HIGH_END);
            default: phase_end = 1'b0;
        endcase
    end

    assign cnt_clr = phase_end || abort_now || (ph == PH_IDLE);
    assign consume = (ph == PH_TAIL) && phase_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            idx     <= '0;
            frm     <= '0;
            clk_low <= 1'b0;
            dat_low <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    clk_low <= 1'b0;
                    dat_low <= 1'b0;
                    if (have_byte && tick && clk_hi && dat_hi) begin
                        frm <= make_frame(held_byte);
                        idx <= '0;
                        ph  <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (abort_now) begin
                        dat_low <= 1'b0;
                        ph      <= PH_IDLE;
                    end else if (phase_end) begin
                        clk_low <= 1'b1;
                        ph      <= PH_LOW;
                    end else if (tick && (cnt == DATA_AT)) begin
                        dat_low <= ~frm[idx];
                    end
                end
                PH_LOW: begin
                    if (phase_end) begin
                        clk_low <= 1'b0;
                        if (idx == STOP_IDX) begin
                            ph <= PH_TAIL;
                        end else begin
                            idx <= idx + 1'b1;
                            ph  <= PH_HIGH;
                        end
                    end
                end
                PH_TAIL: begin
                    dat_low <= 1'b0;
                    if (phase_end) begin
                        ph <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
    import ps2tx_pkg::*;
#(
    parameter int T_LOW       = DEF_T_LOW,
    parameter int T_HIGH      = DEF_T_HIGH,
    parameter int T_SETUP     = DEF_T_SETUP,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_oe,
    output logic       ps2_dat_oe
);
    localparam int T_MAX = (T_HIGH > T_LOW) ? T_HIGH : T_LOW;
    localparam int CNT_W = $clog2(T_MAX + 1) + 1;

    logic [1:0]       line_s;
    logic             have_byte;
    logic [7:0]       held_byte;
    logic             consume;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;

    ps2tx_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({ps2_dat_in, ps2_clk_in}),
        .q   (line_s)
    );

    ps2tx_hold hold_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .consume   (consume),
        .have_byte (have_byte),
        .held_byte (held_byte)
    );

    ps2tx_tick_cnt #(.W(CNT_W)) cnt_i (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (tick_us),
        .cnt (cnt)
    );

    ps2tx_frame #(
        .T_LOW   (T_LOW),
        .T_HIGH  (T_HIGH),
        .T_SETUP (T_SETUP),
        .CNT_W   (CNT_W)
    ) frame_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_us),
        .have_byte (have_byte),
        .held_byte (held_byte),
        .clk_hi    (line_s[0]),
        .dat_hi    (line_s[1]),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .consume   (consume),
        .clk_low   (ps2_clk_oe),
        .dat_low   (ps2_dat_oe)
    );
endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk #(
    parameter int T_LOW = 32
) (
    input logic clk,
    input logic rst,
    input logic tick_us,
    input logic in_valid,
    input logic in_ready,
    input logic ps2_clk_oe,
    input logic ps2_dat_oe
);
    localparam int LW = $clog2(T_LOW + 2) + 1;
    logic [LW-1:0] low_ticks;

    always_ff @(posedge clk) begin
        if (rst || !ps2_clk_oe) begin
            low_ticks <= '0;
        end else if (tick_us) begin
            low_ticks <= low_ticks + 1'b1;
        end
    end

    // R10: lines released and buffer free out of reset
    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (!ps2_clk_oe && !ps2_dat_oe && in_ready));

    // R9: never ready while driving the line
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (ps2_clk_oe || ps2_dat_oe) |-> !in_ready);

    // R9: an accepted byte makes the buffer busy
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R5: data holds still while the clock is pulled low
    p_data_hold_low_r5: assert property (@(posedge clk) disable iff (rst)
        (ps2_clk_oe && $past(ps2_clk_oe)) |-> $stable(ps2_dat_oe));

    // R4: clock enable moves only after a tick
    p_clk_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !tick_us |=> $stable(ps2_clk_oe));

    // R3: low phase length counted in ticks
    p_low_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ps2_clk_oe) |-> (low_ticks == LW'(T_LOW)));
endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.T_LOW(T_LOW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick_us    (tick_us),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .ps2_clk_oe (ps2_clk_oe),
    .ps2_dat_oe (ps2_dat_oe)
);

// File: tb/ps2_dev_tx_tb_top.sv
`timescale 1ns/1ps
module ps2_dev_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready;
    logic       ps2_clk_oe, ps2_dat_oe;
    logic       host_clk_low = 1'b0;
    logic       host_dat_low = 1'b0;
    logic       host_busy = 1'b0;
    logic       ps2_clk_in, ps2_dat_in;

    int total = 0;
    int bad = 0;
    int tnow = 0;
    int bitn = 0;
    int frames_started = 0;
    int frames_done = 0;
    logic [10:0] cap = '0;
    logic [10:0] last_frame = '0;
    logic [10:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign ps2_clk_in = !(ps2_clk_oe || host_clk_low);
    assign ps2_dat_in = !(ps2_dat_oe || host_dat_low);

    ps2_dev_tx dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick_us    (tick_us),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_byte    (in_byte),
        .ps2_clk_in (ps2_clk_in),
        .ps2_dat_in (ps2_dat_in),
        .ps2_clk_oe (ps2_clk_oe),
        .ps2_dat_oe (ps2_dat_oe)
    );

    // tick every fourth clock
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick_us = 1'b1;
            tnow++;
            @(negedge clk);
            tick_us = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // monitor / scoreboard on the device's drive
    logic pc = 1'b0, pd = 1'b0, dchg = 1'b0;
    int t_rise = 0, t_fall = 0, t_dchg = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ps2_clk_oe && !pc) begin
                if (bitn > 0) check_rng("R4 high time", tnow - t_rise, 30, 45);
                if (dchg) check_rng("R5 setup", tnow - t_dchg, 8, 14);
                cap[bitn] = !ps2_dat_oe;
                if (bitn == 0) frames_started++;
                bitn++;
                t_fall = tnow;
                dchg = 1'b0;
            end
            if (!ps2_clk_oe && pc) begin
                check_rng("R3 low time", tnow - t_fall, 30, 35);
                t_rise = tnow;
                if (bitn == 11) begin
                    last_frame = cap;
                    frames_done++;
                    if (exp_q.size() == 0) begin
                        check("R1 R2 unexpected frame", int'(cap), -1);
                    end else begin
                        check("R1 R2 frame content", int'(cap), int'(exp_q.pop_front()));
                    end
                    bitn = 0;
                end
            end
            if (ps2_dat_oe != pd) begin
                if (bitn >= 1 && bitn <= 10 && !host_busy)
                    check_rng("R5 hold", tnow - t_fall, 45, 62);
                t_dchg = tnow;
                dchg = 1'b1;
            end
        end
        pc = ps2_clk_oe;
        pd = ps2_dat_oe;
    end

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        while (!in_ready) @(negedge clk);
        in_byte  = b;
        in_valid = 1'b1;
        exp_q.push_back({1'b1, ~(^b), b, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!in_ready && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(req, int'(in_ready), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 ready after reset", int'(in_ready), 1);
        check("R10 clk released", int'(ps2_clk_oe), 0);
        check("R10 dat released", int'(ps2_dat_oe), 0);

        // R1: byte 58h exact sequence
        send_byte(8'h58);
        check("R9 ready drops on accept", int'(in_ready), 0);
        wait_ready("R9 ready after 58h");
        check("R1 frame of 58h", int'(last_frame), 11'h4B0);
        check("R2 parity of 58h", int'(last_frame[9]), 0);

        // R2: parity over several patterns
        send_byte(8'h00);
        send_byte(8'hFF);
        send_byte(8'hA5);
        send_byte(8'h80);
        wait_ready("R9 ready after burst");
        wait_ticks(5);
        check("R2 burst frames done", frames_done, 5);

        // R6: clock held low by host before the frame
        host_clk_low = 1'b1;
        send_byte(8'h3C);
        wait_ticks(300);
        check("R6 no clk drive under clk inhibit", int'(ps2_clk_oe), 0);
        check("R6 no dat drive under clk inhibit", int'(ps2_dat_oe), 0);
        check("R9 busy while held", int'(in_ready), 0);
        check("R6 nothing started", frames_started, 5);
        host_clk_low = 1'b0;
        wait_ready("R6 ready after release");
        wait_ticks(5);
        check("R6 frame after release", frames_done, 6);

        // R6: data held low by host
        host_dat_low = 1'b1;
        send_byte(8'h96);
        wait_ticks(300);
        check("R6 no clk drive under dat low", int'(ps2_clk_oe), 0);
        check("R6 nothing started dat low", frames_started, 6);
        host_dat_low = 1'b0;
        wait_ready("R6 ready after dat release");
        wait_ticks(5);
        check("R6 frame after dat release", frames_done, 7);

        // R7: inhibit mid-frame aborts and retransmits
        send_byte(8'hC3);
        while (bitn < 4) @(negedge clk);
        host_busy = 1'b1;
        host_clk_low = 1'b1;
        wait_ticks(100);
        check("R7 clk released on abort", int'(ps2_clk_oe), 0);
        check("R7 dat released on abort", int'(ps2_dat_oe), 0);
        check("R9 not ready after abort", int'(in_ready), 0);
        check("R7 no frame completed", frames_done, 7);
        bitn = 0;
        host_clk_low = 1'b0;
        wait_ticks(2);
        host_busy = 1'b0;
        wait_ready("R7 ready after retransmit");
        wait_ticks(5);
        check("R7 frame retransmitted", frames_done, 8);
        check("R7 queue drained", exp_q.size(), 0);

        // R8: inhibit after parity rising edge is ignored
        send_byte(8'h5A);
        while (bitn < 10) @(negedge clk);
        while (ps2_clk_oe) @(negedge clk);
        host_clk_low = 1'b1;
        wait_ticks(20);
        host_clk_low = 1'b0;
        wait_ready("R8 ready after late inhibit");
        wait_ticks(5);
        check("R8 frame completed", frames_done, 9);
        check("R8 queue drained", exp_q.size(), 0);
        wait_ticks(900);
        check("R8 no second copy", frames_started, 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule